// File: doc/BRIEF.md
# Command Word Illegalization Checker

This block sits inside a remote terminal of a MIL-STD-1553 bus interface. When the terminal receives a command word, the block decides whether the command is illegal. It looks the command up in a 256-word table kept in shared RAM. Each of the 4096 combinations can be marked illegal on its own. A combination is made of: the address kind (broadcast or own address), the transmit/receive direction, the 5-bit subaddress and the 5-bit word-count/mode-code field.

A lookup starts with a one-cycle `start` pulse that carries the command word and the broadcast flag. The block forms the table address and issues one read on its RAM port. It waits the read latency, takes the flag bit out of the returned word, and reports the result on `illegal` with a one-cycle `done` pulse. It also reports whether the command was a mode command, which is true for subaddress 0 or 31. A new `start` is not accepted while a lookup is in flight. The table base address, address width and RAM read latency are parameters. The defaults are base 0x300, 16 address bits and one cycle of latency.

Top module: `cwi_lookup`

## Requirements
- R1: While `rst_n` is low, `done`, `illegal`, `mode_cmd` and `ram_re` are all 0.
- R2: A `start` that is accepted on a clock edge makes `ram_re` high for exactly the following cycle. No read is issued without an accepted `start`.
- R3: The read address equals TBL_BASE (default 0x300) with bit 7 set to the inverse of `bcst`. Broadcast lookups therefore land in 0x300–0x37F and own-address lookups in 0x380–0x3FF.
- R4: The command word is laid out as [15:11] terminal address, [10] T/R (1 = transmit), [9:5] subaddress and [4:0] word count/mode code. Address bit 6 is T/R, bits 5:1 are the subaddress and bit 0 is field bit 4. `ram_addr` holds its value from the read until `done`.
- R5: `illegal` equals bit number cmd[3:0] of the word read from the table. A 1 in that bit means illegal.
- R6: `done` is a single-cycle pulse that is visible RD_LAT+1 clock edges after the accepting edge (2 by default). `illegal` changes only together with `done` and holds its value between pulses.
- R7: A `start` on any edge from the one after the accepting edge up to the edge that raises `done` is ignored: no extra read, and the result is unchanged. A `start` in the cycle where `done` is high is accepted.
- R8: `mode_cmd` is 1 with `done` exactly when the subaddress is 0 or 31. The terminal-address field [15:11] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Lookup request, sampled on the rising edge |
| cmd_word | input | 16 | Received command word |
| bcst | input | 1 | 1 = command used the broadcast address |
| ram_re | output | 1 | RAM read enable |
| ram_addr | output | ADDR_W (16) | RAM read address |
| ram_rdata | input | 16 | RAM read data, RD_LAT cycles after `ram_re` |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | 1 = command is illegal |
| mode_cmd | output | 1 | 1 = command addresses subaddress 0 or 31 |

## Verification
The read strobe and its address are due one edge after the accepting edge. The bench checks both at the falling edge that follows. `done`, `illegal` and `mode_cmd` are due on the second edge after acceptance. The bench checks that `done` is still low one falling edge earlier and checks all three results at the falling edge after that second edge. The bench models the RAM with a one-cycle registered read. Because inputs are driven and outputs sampled only on falling edges, every check falls on a fixed cycle counted from the `start` edge. That count also covers extra `start` pulses placed inside the busy window.

// File: rtl/cwi_pkg.sv
package cwi_pkg;
   localparam int CW_W    = 16;
   localparam int FIELD_W = 5;
   localparam int FLAG_W  = 2 ** (FIELD_W - 1);
   localparam int IDX_W   = 8;

   typedef struct packed {
      logic [FIELD_W-1:0] rt;
      logic               tr;
      logic [FIELD_W-1:0] sa;
      logic [FIELD_W-1:0] wc;
   } cmd_t;

   function automatic logic sa_is_mode(input logic [FIELD_W-1:0] sa);
      return (sa == '0) || (sa == '1);
   endfunction
endpackage

// File: rtl/cwi_cmd_latch.sv
module cwi_cmd_latch
   import cwi_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int unsigned TBL_BASE = 'h300
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [CW_W-1:0]       cmd_word,
   input  logic                  bcst,
   output logic [ADDR_W-1:0]     addr_q,
   output logic [FIELD_W-2:0]    sel_q,
   output logic                  mode_q
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(TBL_BASE);

   if (ADDR_W < IDX_W + 1) begin : g_bad_width
      $error("cwi_cmd_latch: ADDR_W too small for table");
   end
   if ((TBL_BASE % (2 ** IDX_W)) != 0) begin : g_bad_align
      $error("cwi_cmd_latch: TBL_BASE must be 256-word aligned");
   end

   cmd_t             cmd;
   logic [IDX_W-1:0] idx;
   logic [ADDR_W-1:0] nxt_addr;
   logic             unused_rt;

   assign cmd       = cmd_t'(cmd_word);
   assign unused_rt = ^cmd.rt;
   assign idx       = {~bcst, cmd.tr, cmd.sa, cmd.wc[FIELD_W-1]};
   assign nxt_addr  = BASE_V | {{(ADDR_W-IDX_W){1'b0}}, idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= BASE_V;
         sel_q  <= '0;
         mode_q <= 1'b0;
      end else if (load) begin
         addr_q <= nxt_addr;
         sel_q  <= cmd.wc[FIELD_W-2:0];
         mode_q <= sa_is_mode(cmd.sa);
      end
   end
endmodule

// File: rtl/cwi_ctrl.sv
module cwi_ctrl #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic ram_re,
   output logic cap_en
);
   if (RD_LAT < 1) begin : g_bad_lat
      $error("cwi_ctrl: RD_LAT must be at least 1");
   end

   logic busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ram_re <= 1'b0;
      else        ram_re <= accept;
   end

   if (RD_LAT == 1) begin : g_lat_one
      logic wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wait_q <= 1'b0;
         else        wait_q <= ram_re;
      end
      assign cap_en = wait_q;
      assign busy   = ram_re | wait_q;
   end else begin : g_lat_chain
      logic [RD_LAT-1:0] wait_sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wait_sr <= '0;
         else        wait_sr <= {wait_sr[RD_LAT-2:0], ram_re};
      end
      assign cap_en = wait_sr[RD_LAT-1];
      assign busy   = ram_re | (|wait_sr);
   end

   assign accept = start & ~busy;
endmodule

// File: rtl/cwi_flag_sel.sv
module cwi_flag_sel
   import cwi_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_en,
   input  logic [DATA_W-1:0]    rdata,
   input  logic [FIELD_W-2:0]   sel,
   input  logic                 mode_in,
   output logic                 done,
   output logic                 illegal,
   output logic                 mode_cmd
);
   if (DATA_W != FLAG_W) begin : g_bad_data
      $error("cwi_flag_sel: DATA_W must equal one flag per low field value");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         illegal  <= 1'b0;
         mode_cmd <= 1'b0;
      end else begin
         done <= cap_en;
         if (cap_en) begin
            illegal  <= rdata[sel];
            mode_cmd <= mode_in;
         end
      end
   end
endmodule

// File: rtl/cwi_lookup.sv
module cwi_lookup
   import cwi_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int unsigned TBL_BASE = 'h300,
   parameter int          RD_LAT   = 1,
   parameter int          DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CW_W-1:0]   cmd_word,
   input  logic              bcst,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              done,
   output logic              illegal,
   output logic              mode_cmd
);
   logic               accept;
   logic               cap_en;
   logic [FIELD_W-2:0] sel_q;
   logic               mode_q;

   cwi_ctrl #(.RD_LAT(RD_LAT)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .ram_re (ram_re),
      .cap_en (cap_en)
   );

   cwi_cmd_latch #(.ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .cmd_word (cmd_word),
      .bcst     (bcst),
      .addr_q   (ram_addr),
      .sel_q    (sel_q),
      .mode_q   (mode_q)
   );

   cwi_flag_sel #(.DATA_W(DATA_W)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .rdata    (ram_rdata),
      .sel      (sel_q),
      .mode_in  (mode_q),
      .done     (done),
      .illegal  (illegal),
      .mode_cmd (mode_cmd)
   );
endmodule

// File: rtl/cwi_lookup_chk.sv
module cwi_lookup_chk #(
   parameter int          ADDR_W   = 16,
   parameter int unsigned TBL_BASE = 'h300,
   parameter int          RD_LAT   = 1,
   parameter int          DATA_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [15:0]       cmd_word,
   input logic              bcst,
   input logic              ram_re,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_rdata,
   input logic              done,
   input logic              illegal,
   input logic              mode_cmd
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(TBL_BASE);
   localparam int CNT_W = $clog2(RD_LAT + 2) + 1;

   logic              pend_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [15:0]       cmd_d;
   logic [3:0]        sel_cap;
   logic [4:0]        sa_cap;
   logic [DATA_W-1:0] data_cap;
   logic              unused_hi;

   assign unused_hi = ^cmd_d[15:11];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         cnt_q    <= '0;
         cmd_d    <= '0;
         sel_cap  <= '0;
         sa_cap   <= '0;
         data_cap <= '0;
      end else begin
         cmd_d <= cmd_word;
         if (ram_re) begin
            pend_q  <= 1'b1;
            cnt_q   <= '0;
            sel_cap <= cmd_d[3:0];
            sa_cap  <= cmd_d[9:5];
         end else if (done) begin
            pend_q <= 1'b0;
         end else if (pend_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (pend_q && cnt_q == CNT_W'(RD_LAT - 1)) data_cap <= ram_rdata;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!done && !ram_re && !illegal && !mode_cmd); // R1
      end
   end

   AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> !ram_re); // R2
   AST_RE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> $past(start)); // R2
   AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> (ram_addr[ADDR_W-1:8] == BASE_V[ADDR_W-1:8]) && (ram_addr[7] == !$past(bcst))); // R3
   AST_ADDR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> ram_addr[6:0] == {$past(cmd_word[10]), $past(cmd_word[9:5]), $past(cmd_word[4])}); // R4
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ram_re) |-> $stable(ram_addr)); // R4
   AST_FLAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> illegal == data_cap[sel_cap]); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pend_q && cnt_q == CNT_W'(RD_LAT))); // R6
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(illegal)); // R6
   AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> !pend_q); // R7
   AST_MODE_SA: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mode_cmd == ((sa_cap == 5'd0) || (sa_cap == 5'd31))); // R8
endmodule

bind cwi_lookup cwi_lookup_chk #(
   .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE), .RD_LAT(RD_LAT), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_cwi_lookup.sv
`timescale 1ns/1ps
module tb_cwi_lookup;
   localparam int ADDR_W = 16;
   localparam int BASE   = 'h300;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [15:0]       cmd_word = '0;
   logic              bcst = 1'b0;
   logic              ram_re;
   logic [ADDR_W-1:0] ram_addr;
   logic [15:0]       ram_rdata = '0;
   logic              done;
   logic              illegal;
   logic              mode_cmd;

   logic [15:0] tbl [256];
   int checks = 0;
   int errors = 0;
   int re_count = 0;
   bit finished = 0;
   bit prev_ill = 0;

   always #2.5 clk = ~clk;

   cwi_lookup dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word), .bcst(bcst),
      .ram_re(ram_re), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
      .done(done), .illegal(illegal), .mode_cmd(mode_cmd)
   );

   always @(posedge clk) begin
      if (ram_re) begin
         ram_rdata <= tbl[ram_addr[7:0]];
         re_count  <= re_count + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int i, input int seed);
      return 16'((i * 40503 + seed * 977) ^ (i << 5) ^ (seed * 3));
   endfunction

   task automatic fill(input int mode);
      for (int i = 0; i < 256; i++)
         tbl[i] = (mode == 0) ? 16'h0000 : (mode == 1) ? 16'hFFFF : pat(i, mode);
   endtask

   task automatic lookup(input bit b, input bit tr, input int sa, input int wc, input int rt, input bit poke);
      logic [15:0] cw;
      int ea;
      bit ei;
      bit em;
      int re0;
      cw = {rt[4:0], tr, sa[4:0], wc[4:0]};
      ea = BASE | (int'(!b) << 7) | (int'(tr) << 6) | (sa << 1) | ((wc >> 4) & 1);
      ei = tbl[ea & 255][wc & 15];
      em = (sa == 0) || (sa == 31);
      @(negedge clk);
      cmd_word = cw; bcst = b; start = 1'b1; re0 = re_count;
      @(negedge clk);
      chk(ram_re == 1'b1, "R2", "read strobe", int'(ram_re), 1);
      chk(ram_addr[ADDR_W-1:7] == 9'(ea >> 7), "R3", "addr base/bcst", int'(ram_addr), ea);
      chk(ram_addr[6:0] == 7'(ea), "R4", "addr fields", int'(ram_addr), ea);
      if (poke) begin cmd_word = ~cw; bcst = !b; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R6", "done early", int'(done), 0);
      chk(illegal == prev_ill, "R6", "result held", int'(illegal), int'(prev_ill));
      chk(ram_addr == 16'(ea), "R4", "addr held", int'(ram_addr), ea);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R6", "done due", int'(done), 1);
      chk(illegal == ei, "R5", "flag bit", int'(illegal), int'(ei));
      chk(mode_cmd == em, "R8", "mode cmd", int'(mode_cmd), int'(em));
      if (poke) begin
         chk(ram_re == 1'b0, "R7", "busy start reissued", int'(ram_re), 0);
         chk(re_count == re0 + 1, "R7", "read count", re_count, re0 + 1);
      end
      prev_ill = ei;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R6 watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      fill(5);
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1", "reset done", int'(done), 0);
      chk(illegal == 1'b0, "R1", "reset illegal", int'(illegal), 0);
      chk(ram_re == 1'b0, "R1", "reset ram_re", int'(ram_re), 0);
      chk(mode_cmd == 1'b0, "R1", "reset mode", int'(mode_cmd), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ram_re == 1'b0, "R2", "no read without start", int'(ram_re), 0);
      // full sweep; terminal address varies to show it is ignored (R8)
      for (int b = 0; b < 2; b++)
         for (int tr = 0; tr < 2; tr++)
            for (int sa = 0; sa < 32; sa++)
               for (int wc = 0; wc < 32; wc++)
                  lookup(b[0], tr[0], sa, wc, (sa * 7 + wc + b) & 31, ((sa + wc) % 7) == 0);
      fill(1);
      for (int b = 0; b < 2; b++)
         for (int wc = 0; wc < 32; wc++) lookup(b[0], wc[0], 31, wc, wc, 1'b0);
      fill(0);
      for (int b = 0; b < 2; b++)
         for (int wc = 0; wc < 32; wc++) lookup(b[0], wc[1], 0, wc, 31 - wc, wc[2]);
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R6", "idle after run", int'(done), 0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule